// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a behavioural model of a synchronous static RAM with registered inputs and a one-stage read pipeline. Each word is made of byte lanes, and each lane holds eight data bits plus one parity bit. The parity bit is stored in the same way as the data bits and is never checked. Address, control and write data are captured on the rising clock edge. A write is committed on that same edge. For a read, the captured address is looked up on the following edge, and the result is held on the output register.

Whether a cycle writes is decided in three levels. A global write strobe overrides everything else. Below it, a lane-write enable admits per-lane selects. A selected cycle that writes no lane is a read. A cycle is selected only when three select inputs agree. The output drive is released asynchronously by an output enable and by a sleep input. The pad enable is low for a write, a deselected cycle and sleep. An external burst sequencer provides the address on every cycle.

Top module: `sync_sram_pipe`

## Requirements
- R1: With the cycle selected and `wr_all_n` low, every lane of the word at `addr` takes `wdata` on that edge, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R2: With the cycle selected, `wr_all_n` high and `lane_wr_en_n` low, lane i (bits 9i+8 down to 9i, with bit 9i+8 the parity bit) is written exactly when `lane_sel_n[i]` is low. Other lanes keep their contents, and any number of lanes may be written at once.
- R3: A selected cycle with `wr_all_n` high and either `lane_wr_en_n` high or all `lane_sel_n` bits high is a read and changes no stored bit.
- R4: A read registered at edge k presents the word at edge k+1. Back-to-back reads stream one word per cycle.
- R5: `dq_en` is high only while the output register holds read data, `oe_n` is low and `sleep` is low. `oe_n` acts at once, without waiting for a clock edge.
- R6: In the cycle after a write's registering edge, `dq_en` is low. The data of a read registered one cycle earlier is still presented in the cycle after that read completes.
- R7: `sleep` high forces `dq_en` low at once.
- R8: A cycle is selected only when `en_n` is low, `sel_hi` is high and `sel_lo_n` is low. An unselected cycle writes nothing and starts no read.
- R9: Deselection releases the output one cycle after the deselecting edge, so a read registered just before it still drives for one cycle.
- R10: While `rst_n` is low, and after it is released, `dq_en` is low until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address from the burst sequencer |
| en_n | input | 1 | Active-low chip enable |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| wr_all_n | input | 1 | Active-low global write, all lanes |
| lane_wr_en_n | input | 1 | Active-low enable for per-lane selects |
| lane_sel_n | input | LANES | Active-low per-lane write selects |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Active-high sleep, releases the output |
| dq_o | output | LANES*LANE_W | Read data toward the pad (zero while released) |
| dq_en | output | 1 | Pad drive enable; low means high-impedance |

## Verification
The bench builds the block with two 9-bit lanes and a 16-word array. At that size, every combination of global write, lane-write enable and lane selects can be swept, each to its own address, and the whole array read back after every pass. All seven partly-deasserted select combinations are tried, and so are the read-to-write and read-to-deselect turnarounds. The output enable and sleep are toggled in the middle of a cycle, which shows that they act without a clock edge.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_ok,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output cyc_e             kind
);
  always_comb begin
    lane_we = '0;
    kind    = CYC_IDLE;
    if (sel_ok) begin
      if (!wr_all_n)          lane_we = '1;
      else if (!lane_wr_en_n) lane_we = ~lane_sel_n;
      kind = (|lane_we) ? CYC_WRITE : CYC_READ;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_lane      <= mem[rd_addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_lane;
  end
endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl #(
  parameter int W = 36
) (
  input  logic         rd_v,
  input  logic         oe_n,
  input  logic         sleep,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] dq_o,
  output logic         dq_en
);
  always_comb begin
    dq_en = rd_v && !oe_n && !sleep;
    dq_o  = dq_en ? rdata : '0;
  end
endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    en_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_en
);
  localparam int W = LANES * LANE_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  logic             sel_ok;
  logic [LANES-1:0] lane_we;
  cyc_e             kind;
  assign sel_ok = rst_ok && !en_n && sel_hi && !sel_lo_n;

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .sel_ok       (sel_ok),
    .wr_all_n     (wr_all_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .lane_we      (lane_we),
    .kind         (kind)
  );

  // stage-1 (registered request) and stage-2 (output valid)
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_v, rd_v_d;

  always_comb begin
    rd_d   = (kind == CYC_READ);
    addr_d = rd_d ? addr : addr_q;
    rd_v_d = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      rd_v   <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      addr_q <= addr_d;
      rd_v   <= rd_v_d;
    end
  end

  logic [W-1:0] rdata;

  sram_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .wr_addr (addr),
    .lane_we (lane_we),
    .wdata   (wdata),
    .rd_en   (rd_q),
    .rd_addr (addr_q),
    .rdata   (rdata)
  );

  sram_out_ctl #(.W(W)) u_out (
    .rd_v  (rd_v),
    .oe_n  (oe_n),
    .sleep (sleep),
    .rdata (rdata),
    .dq_o  (dq_o),
    .dq_en (dq_en)
  );
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             en_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             wr_all_n,
  input logic             lane_wr_en_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic [LANES-1:0] lane_we,
  input logic             oe_n,
  input logic             sleep,
  input logic             dq_en
);
  logic sel;
  assign sel = !en_n && sel_hi && !sel_lo_n;

  p_global_all_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel && !wr_all_n) |-> (lane_we == {LANES{1'b1}}));

  p_lane_pick_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel && wr_all_n && !lane_wr_en_n) |-> (lane_we == ~lane_sel_n));

  p_read_nowr_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel && wr_all_n && (lane_wr_en_n || (&lane_sel_n))) |-> (lane_we == '0));

  p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    oe_n |-> !dq_en);

  p_write_hiz_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel && (lane_we != '0)) |=> ##1 !dq_en);

  p_sleep_hiz_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    sleep |-> !dq_en);

  p_desel_nowr_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel |-> (lane_we == '0));

  p_desel_hiz_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel |=> ##1 !dq_en);
endmodule

bind sync_sram_pipe sram_pipe_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .en_n         (en_n),
  .sel_hi       (sel_hi),
  .sel_lo_n     (sel_lo_n),
  .wr_all_n     (wr_all_n),
  .lane_wr_en_n (lane_wr_en_n),
  .lane_sel_n   (lane_sel_n),
  .lane_we      (lane_we),
  .oe_n         (oe_n),
  .sleep        (sleep),
  .dq_en        (dq_en)
);

// File: tb/sync_sram_pipe_test.sv
`timescale 1ns/1ps
module sync_sram_pipe_test;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 4;
  localparam int W      = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              en_n, sel_hi, sel_lo_n, wr_all_n, lane_wr_en_n;
  logic [LANES-1:0]  lane_sel_n;
  logic [W-1:0]      wdata;
  logic              oe_n, sleep;
  logic [W-1:0]      dq_o;
  logic              dq_en;

  logic [W-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sync_sram_pipe #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_n(en_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .dq_o(dq_o), .dq_en(dq_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    en_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    wdata = '0; addr = '0;
  endtask

  function automatic logic [W-1:0] pat(input int a, input int k);
    return W'((a * 32'h2F3) ^ (k * 32'h1D1) ^ 32'h155 ^ (a << 13));
  endfunction

  // one selected write-path cycle; model follows the requirement rules
  task automatic wr_cyc(input int a, input logic [W-1:0] d, input logic gw_n,
                        input logic bwe_n, input logic [LANES-1:0] s_n);
    en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    addr = ADDR_W'(a); wdata = d; wr_all_n = gw_n;
    lane_wr_en_n = bwe_n; lane_sel_n = s_n;
    for (int l = 0; l < LANES; l++)
      if (!gw_n || (!bwe_n && !s_n[l]))
        model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    tick();
  endtask

  task automatic rd_drive(input int a, input bit alt);
    en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    addr = ADDR_W'(a); wr_all_n = 1'b1; wdata = '1;
    lane_wr_en_n = alt ? 1'b0 : 1'b1;  // alt: enable low, selects all high
    lane_sel_n = alt ? '1 : '0;
  endtask

  // streaming read of the whole array, one address per cycle
  task automatic read_all(input string req);
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (i >= 2) begin
        chk(dq_en === 1'b1, req, 32'(dq_en), 1);
        chk(dq_o === model[i-2], req, 32'(dq_o), 32'(model[i-2]));
      end
      if (i < DEPTH) rd_drive(i, i[0]);
      else idle();
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    idle();
    repeat (3) tick();
    chk(dq_en === 1'b0, "R10", 32'(dq_en), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(dq_en === 1'b0, "R10", 32'(dq_en), 0);

    // R1: global write with junk on the lane controls
    for (int a = 0; a < DEPTH; a++)
      wr_cyc(a, pat(a, 1), 1'b0, a[0], LANES'(a >> 1));
    idle(); tick();
    read_all("R1");
    // R4 also covered: streamed reads at one word per cycle
    read_all("R4");

    // R2/R3: sweep every write-control combination
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 16; c++) begin
        wr_cyc(c, pat(c, 7 + pass), 1'(c >> 3), 1'(c >> 2), LANES'(c));
      end
      idle(); tick();
      read_all("R2");
    end
    read_all("R3");

    // R8: each partly deasserted select combination blocks a global write
    for (int s = 0; s < 8; s++) begin
      if (s == 3'b010) continue;  // en_n=0 sel_hi=1 sel_lo_n=0 is selected
      en_n = s[2]; sel_hi = s[1]; sel_lo_n = s[0];
      addr = ADDR_W'(s); wdata = ~model[s]; wr_all_n = 1'b0;
      lane_wr_en_n = 1'b0; lane_sel_n = '0;
      tick();
      idle(); tick();
      chk(dq_en === 1'b0, "R8", 32'(dq_en), 0);
    end
    read_all("R8");

    // R9: read then deselect - one more driven cycle, then released
    rd_drive(5, 1'b0); tick();
    idle(); tick();
    chk(dq_en === 1'b1, "R9", 32'(dq_en), 1);
    chk(dq_o === model[5], "R9", 32'(dq_o), 32'(model[5]));
    tick();
    chk(dq_en === 1'b0, "R9", 32'(dq_en), 0);

    // R6: read followed by write - read data still out, then released
    rd_drive(6, 1'b0); tick();
    wr_cyc(9, pat(9, 40), 1'b0, 1'b1, '1);
    idle();
    chk(dq_en === 1'b1, "R6", 32'(dq_en), 1);
    chk(dq_o === model[6], "R6", 32'(dq_o), 32'(model[6]));
    tick();
    chk(dq_en === 1'b0, "R6", 32'(dq_en), 0);

    // R5/R7: asynchronous release mid-cycle
    rd_drive(9, 1'b0); tick();
    idle(); tick();
    chk(dq_o === model[9], "R5", 32'(dq_o), 32'(model[9]));
    #2 oe_n = 1'b1; #1;
    chk(dq_en === 1'b0, "R5", 32'(dq_en), 0);
    oe_n = 1'b0; #1;
    chk(dq_en === 1'b1, "R5", 32'(dq_en), 1);
    sleep = 1'b1; #1;
    chk(dq_en === 1'b0, "R7", 32'(dq_en), 0);
    sleep = 1'b0; #1;
    chk(dq_en === 1'b1, "R7", 32'(dq_en), 1);
    tick();

    // R5: read issued with oe_n high, enabled late without a clock
    oe_n = 1'b1;
    rd_drive(3, 1'b1); tick();
    idle(); tick();
    chk(dq_en === 1'b0, "R5", 32'(dq_en), 0);
    #3 oe_n = 1'b0; #1;
    chk(dq_en === 1'b1, "R5", 32'(dq_en), 1);
    chk(dq_o === model[3], "R5", 32'(dq_o), 32'(model[3]));
    tick();

    // R10: reset in mid-stream releases the output
    rd_drive(2, 1'b0); tick();
    rst_n = 1'b0; #1;
    chk(dq_en === 1'b0, "R10", 32'(dq_en), 0);
    idle(); tick(); rst_n = 1'b1; repeat (4) tick();
    chk(dq_en === 1'b0, "R10", 32'(dq_en), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule